// File: doc/BRIEF.md
# Four-Port GPIO Controller with Set/Clear Access

This block is a memory-mapped general-purpose I/O controller for four pin groups. Ports 0, 1 and 2 are bidirectional, and each pin has its own direction bit. Port 3 is a mixed bank with three kinds of pin:

- six bidirectional pins;
- a set of input-only lines;
- 24 output-only lines.

Software never writes an output level or a direction directly. Writing a 1 to a set register raises the chosen latch bits, and writing a 1 to a clear register lowers them. State registers return the synchronized pin inputs, the driven output latches and the directions.

The bus is a simple register port. A write takes effect at the rising clock edge when `bus_we` is high. A read is combinational from `bus_addr`, with no wait states. Each pin's output-enable is its direction bit, and each pad output value is its output latch bit. The two are independent, so a level written while a pin is an input appears as soon as the pin becomes an output.

Port 3 does not use a contiguous layout. The bidirectional pins occupy bits 25 to 30 for output level and direction, and their direction lives in port 2's direction registers. Their inputs read back at bits 10 to 14 and bit 24 of the port 3 input-state word. Every other bit of that word up to bit 27 belongs to the input-only lines.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every output-enable and every output level is 0, and every state register reads 0.
- R2: On ports 0 to 2, writing to the output-set address (port 0 at 0x44, port 1 at 0x64, port 2 at 0x20) sets each latch bit whose data bit is 1. Writing to the output-clear address (0x48, 0x68, 0x24) clears each latch bit whose data bit is 1. Data bits that are 0 leave their latches unchanged, and pin n uses bit n.
- R3: Writing to a direction-set address (port 0 at 0x50, port 1 at 0x70, port 2 at 0x10) makes each selected pin an output. The matching direction-clear address (0x54, 0x74, 0x14) makes each selected pin an input. The output-enable equals the direction bit, and the pad output equals the latch whatever the direction.
- R4: Each port has state registers:
  - port 0 returns output state at 0x4C and direction state at 0x58;
  - port 1 returns output state at 0x6C and direction state at 0x78;
  - port 2 returns direction state at 0x18.
- R5: Port 3 bidirectional pin n uses bit n+25 of the port 3 output set/clear registers (0x04 and 0x08) for its level. Its direction uses the same bit of the port 2 direction set, clear and state registers (0x10, 0x14 and 0x18).
- R6: The port 3 input-state word at 0x00 is laid out as follows:
  - bits 10 to 14 carry bidirectional pins 0 to 4;
  - bit 24 carries bidirectional pin 5;
  - bits 0 to 9, 15 to 23 and 25 to 27 carry the same-numbered input-only lines;
  - bits 28 to 31 read 0.
  The input-only lines at positions 10 to 14 and 24 have no effect.
- R7: Output-only pins 0 to 23 are set and cleared through bits 0 to 23 of 0x04 and 0x08. Bits 24 and 31 of those writes are ignored. The output-state word at 0x0C returns the output-only latches in bits 0 to 23 and the bidirectional latches in bits 25 to 30.
- R8: Each pin input passes through two flops. A change at a pin appears in its input-state read (port 0 at 0x40, port 1 at 0x60, port 2 at 0x1C, port 3 at 0x00) after the second rising edge, and not after the first.
- R9: The following reads return 0:
  - the write-only set and clear addresses;
  - any address not listed above.
  Writes to state addresses or unlisted addresses change no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pa_in | input | P0_W | Port 0 pin inputs |
| pa_oe | output | P0_W | Port 0 output-enables |
| pa_out | output | P0_W | Port 0 output levels |
| pb_in | input | P1_W | Port 1 pin inputs |
| pb_oe | output | P1_W | Port 1 output-enables |
| pb_out | output | P1_W | Port 1 output levels |
| pc_in | input | P2_W | Port 2 pin inputs |
| pc_oe | output | P2_W | Port 2 output-enables |
| pc_out | output | P2_W | Port 2 output levels |
| pd_io_in | input | 6 | Port 3 bidirectional pin inputs |
| pd_io_oe | output | 6 | Port 3 bidirectional output-enables |
| pd_io_out | output | 6 | Port 3 bidirectional output levels |
| pd_gi_in | input | 28 | Port 3 input-only lines |
| pd_go_out | output | 24 | Port 3 output-only levels |

## Verification
The hardest situation to reach is the aliasing inside the port 3 registers. One set or clear write touches two unrelated pin groups at once, and one input-state word mixes two groups at scattered positions. The stimulus therefore drives every input-only line high while the bidirectional inputs are low, then the reverse, then a single bidirectional pin at each end of its range. This exposes any swap, shift or merge at bits 10 to 14 and 24. For port 3 direction, a write through the port 2 direction registers must move the bidirectional output-enables and leave port 2's own direction bits alone. For port 3 outputs, set and clear writes carry bits in both halves of the word plus the ignored bits 24 and 31.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int P0_W = 8,
  parameter int P1_W = 24,
  parameter int P2_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [P0_W-1:0]  pa_in,
  output logic [P0_W-1:0]  pa_oe,
  output logic [P0_W-1:0]  pa_out,
  input  logic [P1_W-1:0]  pb_in,
  output logic [P1_W-1:0]  pb_oe,
  output logic [P1_W-1:0]  pb_out,
  input  logic [P2_W-1:0]  pc_in,
  output logic [P2_W-1:0]  pc_oe,
  output logic [P2_W-1:0]  pc_out,
  input  logic [5:0]       pd_io_in,
  output logic [5:0]       pd_io_oe,
  output logic [5:0]       pd_io_out,
  input  logic [27:0]      pd_gi_in,
  output logic [23:0]      pd_go_out
);
  localparam logic [7:0] A_P3_IN  = 8'h00, A_P3_OS  = 8'h04, A_P3_OC  = 8'h08, A_P3_OST = 8'h0C;
  localparam logic [7:0] A_P2_DS  = 8'h10, A_P2_DC  = 8'h14, A_P2_DST = 8'h18, A_P2_IN  = 8'h1C;
  localparam logic [7:0] A_P2_OS  = 8'h20, A_P2_OC  = 8'h24;
  localparam logic [7:0] A_P0_IN  = 8'h40, A_P0_OS  = 8'h44, A_P0_OC  = 8'h48, A_P0_OST = 8'h4C;
  localparam logic [7:0] A_P0_DS  = 8'h50, A_P0_DC  = 8'h54, A_P0_DST = 8'h58;
  localparam logic [7:0] A_P1_IN  = 8'h60, A_P1_OS  = 8'h64, A_P1_OC  = 8'h68, A_P1_OST = 8'h6C;
  localparam logic [7:0] A_P1_DS  = 8'h70, A_P1_DC  = 8'h74, A_P1_DST = 8'h78;

  localparam int IO_N = 6;
  localparam int GI_N = 28;
  localparam int GO_N = 24;
  localparam int BIO_LSB = 25;
  localparam int O1 = P0_W;
  localparam int O2 = O1 + P1_W;
  localparam int O3 = O2 + P2_W;
  localparam int O4 = O3 + IO_N;
  localparam int IN_W = O4 + GI_N;

  logic [P0_W-1:0] p0_out, p0_dir;
  logic [P1_W-1:0] p1_out, p1_dir;
  logic [P2_W-1:0] p2_out, p2_dir;
  logic [IO_N-1:0] p3b_out, p3b_dir;
  logic [GO_N-1:0] p3o_out;
  logic [IN_W-1:0] sy1, sy2;
  logic [31:0]     p3_in;

  wire [IO_N-1:0] wd_bio = bus_wdata[BIO_LSB +: IO_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_out <= '0; p0_dir <= '0;
      p1_out <= '0; p1_dir <= '0;
      p2_out <= '0; p2_dir <= '0;
      p3b_out <= '0; p3b_dir <= '0;
      p3o_out <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_P0_OS: p0_out <= p0_out | bus_wdata[P0_W-1:0];
        A_P0_OC: p0_out <= p0_out & ~bus_wdata[P0_W-1:0];
        A_P0_DS: p0_dir <= p0_dir | bus_wdata[P0_W-1:0];
        A_P0_DC: p0_dir <= p0_dir & ~bus_wdata[P0_W-1:0];
        A_P1_OS: p1_out <= p1_out | bus_wdata[P1_W-1:0];
        A_P1_OC: p1_out <= p1_out & ~bus_wdata[P1_W-1:0];
        A_P1_DS: p1_dir <= p1_dir | bus_wdata[P1_W-1:0];
        A_P1_DC: p1_dir <= p1_dir & ~bus_wdata[P1_W-1:0];
        A_P2_OS: p2_out <= p2_out | bus_wdata[P2_W-1:0];
        A_P2_OC: p2_out <= p2_out & ~bus_wdata[P2_W-1:0];
        A_P2_DS: begin
          p2_dir  <= p2_dir | bus_wdata[P2_W-1:0];
          p3b_dir <= p3b_dir | wd_bio;
        end
        A_P2_DC: begin
          p2_dir  <= p2_dir & ~bus_wdata[P2_W-1:0];
          p3b_dir <= p3b_dir & ~wd_bio;
        end
        A_P3_OS: begin
          p3o_out <= p3o_out | bus_wdata[GO_N-1:0];
          p3b_out <= p3b_out | wd_bio;
        end
        A_P3_OC: begin
          p3o_out <= p3o_out & ~bus_wdata[GO_N-1:0];
          p3b_out <= p3b_out & ~wd_bio;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= {pd_gi_in, pd_io_in, pc_in, pb_in, pa_in};
      sy2 <= sy1;
    end
  end

  always_comb begin
    p3_in = {4'b0, sy2[O4 +: GI_N]};
    p3_in[14:10] = sy2[O3 +: 5];
    p3_in[24] = sy2[O3 + 5];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_P3_IN:  bus_rdata = p3_in;
      A_P3_OST: bus_rdata = {1'b0, p3b_out, 1'b0, p3o_out};
      A_P2_DST: bus_rdata = 32'(p2_dir) | {1'b0, p3b_dir, 25'b0};
      A_P2_IN:  bus_rdata = 32'(sy2[O2 +: P2_W]);
      A_P0_IN:  bus_rdata = 32'(sy2[0 +: P0_W]);
      A_P0_OST: bus_rdata = 32'(p0_out);
      A_P0_DST: bus_rdata = 32'(p0_dir);
      A_P1_IN:  bus_rdata = 32'(sy2[O1 +: P1_W]);
      A_P1_OST: bus_rdata = 32'(p1_out);
      A_P1_DST: bus_rdata = 32'(p1_dir);
      default:  bus_rdata = '0;
    endcase
  end

  assign pa_oe = p0_dir;   assign pa_out = p0_out;
  assign pb_oe = p1_dir;   assign pb_out = p1_out;
  assign pc_oe = p2_dir;   assign pc_out = p2_out;
  assign pd_io_oe = p3b_dir;
  assign pd_io_out = p3b_out;
  assign pd_go_out = p3o_out;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31], bus_wdata[24], sy2[O4 + 10 +: 5], sy2[O4 + 24]};
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int P0_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [7:0]      bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [31:0]     bus_rdata,
  input logic [P0_W-1:0] pa_in,
  input logic [P0_W-1:0] pa_oe,
  input logic [P0_W-1:0] pa_out,
  input logic [5:0]      pd_io_oe,
  input logic [23:0]     pd_go_out
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;

  // R2
  p0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h44) |=> ((pa_out & $past(bus_wdata[P0_W-1:0])) == $past(bus_wdata[P0_W-1:0])));
  // R2
  p0_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h48) |=> ((pa_out & $past(bus_wdata[P0_W-1:0])) == '0));
  // R9
  p0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == 8'h44 || bus_addr == 8'h48)) |=> $stable(pa_out));
  // R3
  p0_dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h50) |=> ((pa_oe & $past(bus_wdata[P0_W-1:0])) == $past(bus_wdata[P0_W-1:0])));
  // R5
  p3_dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h10) |=> ((pd_io_oe & $past(bus_wdata[30:25])) == $past(bus_wdata[30:25])));
  // R7
  gpo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h08) |=> ((pd_go_out & $past(bus_wdata[23:0])) == '0));
  // R9
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h04 || bus_addr == 8'h44 || bus_addr == 8'h54 || bus_addr == 8'h30) |-> (bus_rdata == '0));
  // R8
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && bus_addr == 8'h40) |-> (bus_rdata[P0_W-1:0] == $past(pa_in, 2)));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.P0_W(P0_W)) u_chk (.*);

// File: tb/gpio_bank_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0] pa_in = 0, pa_oe, pa_out;
  logic [23:0] pb_in = 0, pb_oe, pb_out;
  logic [12:0] pc_in = 0, pc_oe, pc_out;
  logic [5:0] pd_io_in = 0, pd_io_oe, pd_io_out;
  logic [27:0] pd_gi_in = 0;
  logic [23:0] pd_go_out;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  gpio_bank_ctrl u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_addr = 8'hFC; bus_wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata; bus_addr = 8'hFC;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 oe", {pa_oe, pb_oe}, 0);
    chk("R1 out", {pa_out, pb_out}, 0);
    chk("R1 p2/p3", {pc_oe, pc_out, pd_io_oe, pd_io_out}, 0);
    chk("R1 gpo", pd_go_out, 0);
    rd(8'h0C, d); chk("R1 p3 ostate", d, 0);
    rd(8'h58, d); chk("R1 p0 dstate", d, 0);
  endtask

  task automatic t_port0;
    logic [31:0] d;
    wr(8'h44, 32'hA5); chk("R2 p0 set", pa_out, 8'hA5);
    wr(8'h48, 32'h05); chk("R2 p0 clr", pa_out, 8'hA0);
    wr(8'h44, 32'h0);  chk("R2 p0 zero bits", pa_out, 8'hA0);
    rd(8'h4C, d); chk("R4 p0 ostate", d, 32'hA0);
    wr(8'h50, 32'h0F); chk("R3 p0 dir set", pa_oe, 8'h0F);
    wr(8'h54, 32'h03); chk("R3 p0 dir clr", pa_oe, 8'h0C);
    chk("R3 out indep of dir", pa_out, 8'hA0);
    rd(8'h58, d); chk("R4 p0 dstate", d, 32'h0C);
  endtask

  task automatic t_port1;
    logic [31:0] d;
    wr(8'h64, 32'hFFFF_FFFF); chk("R2 p1 set", pb_out, 24'hFFFFFF);
    wr(8'h68, 32'h00F0F0);    chk("R2 p1 clr", pb_out, 24'hFF0F0F);
    rd(8'h6C, d); chk("R4 p1 ostate", d, 32'hFF0F0F);
    wr(8'h70, 32'h800001); chk("R3 p1 dir set", pb_oe, 24'h800001);
    wr(8'h74, 32'h000001); chk("R3 p1 dir clr", pb_oe, 24'h800000);
    rd(8'h78, d); chk("R4 p1 dstate", d, 32'h800000);
  endtask

  task automatic t_port2;
    wr(8'h20, 32'h1FFF); chk("R2 p2 set", pc_out, 13'h1FFF);
    wr(8'h24, 32'h1000); chk("R2 p2 clr", pc_out, 13'h0FFF);
    wr(8'h10, 32'h0003); chk("R3 p2 dir set", pc_oe, 13'h0003);
  endtask

  task automatic t_p3bidir;
    logic [31:0] d;
    wr(8'h10, (32'h1 << 25) | (32'h1 << 30));
    chk("R5 p3 dir via p2", pd_io_oe, 6'b100001);
    chk("R5 p2 dir untouched", pc_oe, 13'h0003);
    rd(8'h18, d); chk("R5 dstate", d, 32'h4200_0003);
    wr(8'h04, 32'h3F << 25);
    chk("R5 p3 bidir out", pd_io_out, 6'h3F);
    chk("R5 gpo untouched", pd_go_out, 0);
    wr(8'h14, 32'h1 << 25); chk("R5 p3 dir clr", pd_io_oe, 6'b100000);
  endtask

  task automatic t_gpo;
    logic [31:0] d;
    wr(8'h04, 32'h0081_0001); chk("R7 gpo set", pd_go_out, 24'h810001);
    wr(8'h08, 32'h8100_0001); chk("R7 gpo clr", pd_go_out, 24'h810000);
    chk("R7 bit31/24 ignored", pd_io_out, 6'h3F);
    rd(8'h0C, d); chk("R7 ostate", d, 32'h7E81_0000);
  endtask

  task automatic t_p3in;
    logic [31:0] d;
    @(negedge clk); pd_gi_in = 28'hFFF_FFFF; pd_io_in = 0;
    repeat (3) @(negedge clk);
    rd(8'h00, d); chk("R6 gpi only", d, 32'h0EFF_83FF);
    @(negedge clk); pd_gi_in = 0; pd_io_in = 6'h3F;
    repeat (3) @(negedge clk);
    rd(8'h00, d); chk("R6 bidir only", d, 32'h0100_7C00);
    @(negedge clk); pd_io_in = 6'b100001;
    repeat (3) @(negedge clk);
    rd(8'h00, d); chk("R6 bidir pin0/pin5", d, 32'h0100_0400);
    @(negedge clk); pd_io_in = 0;
  endtask

  task automatic t_sync;
    @(negedge clk); pa_in = 8'h00; pc_in = 13'h0;
    repeat (3) @(negedge clk);
    pa_in = 8'h5A; bus_addr = 8'h40;
    @(negedge clk); #1; chk("R8 not after first edge", bus_rdata, 0);
    @(negedge clk); #1; chk("R8 after second edge", bus_rdata, 32'h5A);
    pc_in = 13'h1234; bus_addr = 8'h1C;
    repeat (2) @(negedge clk); #1; chk("R8 p2 input", bus_rdata, 32'h1234);
    pb_in = 24'hABCDEF; bus_addr = 8'h60;
    repeat (2) @(negedge clk); #1; chk("R8 p1 input", bus_rdata, 32'hABCDEF);
    bus_addr = 8'hFC;
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    logic [7:0] wo [12] = '{8'h04, 8'h08, 8'h10, 8'h14, 8'h20, 8'h24,
                            8'h44, 8'h48, 8'h50, 8'h54, 8'h64, 8'h70};
    foreach (wo[i]) begin
      rd(wo[i], d); chk("R9 write-only read", d, 0);
    end
    rd(8'h30, d); chk("R9 unmapped 30", d, 0);
    rd(8'h42, d); chk("R9 unaligned", d, 0);
    rd(8'h80, d); chk("R9 unmapped 80", d, 0);
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h4C, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF);
    chk("R9 p0 unchanged", {pa_out, pa_oe}, {8'hA0, 8'h0C});
    chk("R9 gpo unchanged", pd_go_out, 24'h810000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_port0; t_port1; t_port2; t_p3bidir; t_gpo; t_p3in; t_sync; t_unmapped;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule